// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer Register File

This block holds a 16-bit free-running up-counter, a 16-bit compare value and a 16-bit capture value. Software reaches all three through an 8-bit register bus. The counter advances by one on each cycle where an external prescaler asserts a clock-enable tick. Each time the counter steps onto the compare value, the block emits a one-cycle match pulse. A selectable edge on an external capture input copies the live count into the capture register.

A byte-wide bus cannot move a 16-bit value in one access, so all three registers share one holding byte, and that byte makes each 16-bit access atomic. On a write, software sends the high byte first, and that byte only fills the holding byte. The low-byte write then commits the full word in one cycle. On a read, software reads the low byte first, which parks the matching high byte in the holding byte. Any high-byte read returns the holding byte.

Top module: `byte_timer16`

## Requirements
- R1: A write to a high-byte address (1, 3 or 5) loads only the holding byte. The counter, compare and capture registers keep their values.
- R2: A write to counter-low (address 0) or compare-low (address 2) sets that register to {holding byte, written byte} in the same clock edge.
- R3: A read at a low-byte address (0, 2, 4) returns bits 7:0 of that register and, at the clock edge, copies its bits 15:8 into the holding byte. A read at any high-byte address returns the holding byte.
- R4: The counter increments by one on each clock edge where `tick` is high and wraps from 0xFFFF to 0x0000. Without a tick or a load it holds its value.
- R5: When a counter-low write and a tick fall on the same edge, the written value is taken unchanged. Counting resumes from that value on the next tick.
- R6: `match_pulse` is high for exactly the one cycle after a tick edge that stepped the counter onto the compare value. A counter load never raises it.
- R7: A capture edge copies the counter into the capture register. `cap_rise`=1 selects rising edges and `cap_rise`=0 selects falling edges. The other edge is ignored. A write to capture-low (address 4) is ignored.
- R8: Synchronous reset clears the counter, the compare register, the capture register and the holding byte, and drives `match_pulse` low.
- R9: Addresses 6 and 7 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock-enable from the prescaler |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (has side effects on low-byte reads) |
| bus_addr | input | 3 | Byte address: 0/1 counter lo/hi, 2/3 compare lo/hi, 4/5 capture lo/hi |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| cap_pin | input | 1 | Capture trigger input |
| cap_rise | input | 1 | Capture edge select: 1 rising, 0 falling |
| match_pulse | output | 1 | One-cycle compare-match pulse |

## Verification
The assertions check the counter's hold and increment rules, the immunity of the compare register to high-byte writes, the one-cycle compare commit, the width and value of the match pulse, and the state right after reset. These checks run on every cycle. Read side effects on the holding byte, the byte ordering across the three registers, the capture edge selection and the result of a counter load that collides with a tick show only in the bench's access sequences.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned ADDR_W = 3;

    // Register group selected by address bits [2:1]
    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_CAP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     hi;
    } bus_dec_t;

    function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        d.sel = reg_sel_e'(a[2:1]);
        d.hi  = a[0];
        return d;
    endfunction

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [WORD_W-1:0] w);
        return w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic [WORD_W-1:0] cmp,
    output logic [WORD_W-1:0] cnt,
    output logic              match
);
    logic [WORD_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt + WORD_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            match <= 1'b0;
        end else begin
            match <= tick && !load && (cnt_nxt == cmp);
            if (load) begin
                cnt <= load_val;
            end else if (tick) begin
                cnt <= cnt_nxt;
            end
        end
    end
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic              rise_sel,
    input  logic [WORD_W-1:0] cnt,
    output logic [WORD_W-1:0] cap
);
    logic pin_q;
    logic pin_prev;
    logic edge_hit;

    assign edge_hit = rise_sel ? (pin_q & ~pin_prev) : (~pin_q & pin_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b0;
            pin_prev <= 1'b0;
            cap      <= '0;
        end else begin
            pin_q    <= pin;
            pin_prev <= pin_q;
            if (edge_hit) begin
                cap <= cnt;
            end
        end
    end
endmodule

// File: rtl/tmr16_holdreg.sv
module tmr16_holdreg
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_dec_t          dec,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [WORD_W-1:0] cnt,
    input  logic [WORD_W-1:0] cmp,
    input  logic [WORD_W-1:0] cap,
    output logic [BYTE_W-1:0] temp,
    output logic [BYTE_W-1:0] rdata
);
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        case (dec.sel)
            SEL_CNT: sel_word = cnt;
            SEL_CMP: sel_word = cmp;
            SEL_CAP: sel_word = cap;
            default: sel_word = '0;
        endcase
    end

    always_comb begin
        if (dec.sel == SEL_NONE) begin
            rdata = '0;
        end else if (dec.hi) begin
            rdata = temp;
        end else begin
            rdata = lo_byte(sel_word);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            temp <= '0;
        end else if (dec.sel != SEL_NONE) begin
            if (wr_en && dec.hi) begin
                temp <= wdata;
            end else if (rd_en && !dec.hi && !wr_en) begin
                temp <= hi_byte(sel_word);
            end
        end
    end
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cap_pin,
    input  logic              cap_rise,
    output logic              match_pulse
);
    bus_dec_t          dec;
    logic [BYTE_W-1:0] temp;
    logic [WORD_W-1:0] cnt_q;
    logic [WORD_W-1:0] cmp_q;
    logic [WORD_W-1:0] cap_q;
    logic [WORD_W-1:0] commit_word;
    logic              cnt_load;
    logic              cmp_load;

    assign dec         = decode_addr(bus_addr);
    assign commit_word = {temp, bus_wdata};
    assign cnt_load    = bus_wr && !dec.hi && (dec.sel == SEL_CNT);
    assign cmp_load    = bus_wr && !dec.hi && (dec.sel == SEL_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (cmp_load) begin
            cmp_q <= commit_word;
        end
    end

    tmr16_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (commit_word),
        .cmp      (cmp_q),
        .cnt      (cnt_q),
        .match    (match_pulse)
    );

    tmr16_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .pin      (cap_pin),
        .rise_sel (cap_rise),
        .cnt      (cnt_q),
        .cap      (cap_q)
    );

    tmr16_holdreg u_hold (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .wr_en (bus_wr),
        .rd_en (bus_rd),
        .wdata (bus_wdata),
        .cnt   (cnt_q),
        .cmp   (cmp_q),
        .cap   (cap_q),
        .temp  (temp),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/byte_timer16_chk.sv
module byte_timer16_chk
    import tmr16_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              cnt_load,
    input logic [BYTE_W-1:0] temp,
    input logic [WORD_W-1:0] cnt,
    input logic [WORD_W-1:0] cmp,
    input logic              match
);
    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (cnt == '0 && cmp == '0 && !match));

    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_load) |=> $stable(cnt));

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_load) |=> (cnt == $past(cnt) + WORD_W'(1)));

    assert_hi_write_keeps_cmp_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3) |=> $stable(cmp));

    assert_cmp_commit_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd2) |=> (cmp == {$past(temp), $past(bus_wdata)}));

    assert_match_single_R6: assert property (@(posedge clk) disable iff (rst)
        match |=> !match);

    assert_match_value_R6: assert property (@(posedge clk) disable iff (rst)
        match |-> (cnt == $past(cmp)));
endmodule

bind byte_timer16 byte_timer16_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_load  (cnt_load),
    .temp      (temp),
    .cnt       (cnt_q),
    .cmp       (cmp_q),
    .match     (match_pulse)
);

// File: tb/test_byte_timer16.sv
`timescale 1ns/1ps
module test_byte_timer16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       cap_rise = 1'b1;
    logic       match_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    byte_timer16 i_byte_timer16 (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cap_pin     (cap_pin),
        .cap_rise    (cap_rise),
        .match_pulse (match_pulse)
    );

    // kind: 0 write, 1 read-and-compare, 2 tick for `data` cycles
    typedef struct packed {
        logic [1:0] kind;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        // compare register, byte order (R1, R2, R3)
        '{2'd0, 3'd3, 8'h12, 8'h00, 4'd1},
        '{2'd1, 3'd3, 8'h00, 8'h12, 4'd3},
        '{2'd0, 3'd2, 8'h34, 8'h00, 4'd2},
        '{2'd1, 3'd2, 8'h00, 8'h34, 4'd2},
        '{2'd1, 3'd3, 8'h00, 8'h12, 4'd2},
        '{2'd0, 3'd3, 8'h77, 8'h00, 4'd1},
        '{2'd1, 3'd2, 8'h00, 8'h34, 4'd1},
        '{2'd1, 3'd3, 8'h00, 8'h12, 4'd1},
        // counter load and counting, carry and wrap (R2, R4)
        '{2'd0, 3'd1, 8'h00, 8'h00, 4'd2},
        '{2'd0, 3'd0, 8'h05, 8'h00, 4'd2},
        '{2'd1, 3'd0, 8'h00, 8'h05, 4'd2},
        '{2'd1, 3'd1, 8'h00, 8'h00, 4'd2},
        '{2'd2, 3'd0, 8'd3,  8'h00, 4'd4},
        '{2'd1, 3'd0, 8'h00, 8'h08, 4'd4},
        '{2'd0, 3'd1, 8'h01, 8'h00, 4'd2},
        '{2'd0, 3'd0, 8'hFE, 8'h00, 4'd2},
        '{2'd2, 3'd0, 8'd3,  8'h00, 4'd4},
        '{2'd1, 3'd0, 8'h00, 8'h01, 4'd4},
        '{2'd1, 3'd1, 8'h00, 8'h02, 4'd4},
        '{2'd0, 3'd1, 8'hFF, 8'h00, 4'd2},
        '{2'd0, 3'd0, 8'hFF, 8'h00, 4'd2},
        '{2'd2, 3'd0, 8'd1,  8'h00, 4'd4},
        '{2'd1, 3'd0, 8'h00, 8'h00, 4'd4},
        '{2'd1, 3'd1, 8'h00, 8'h00, 4'd4},
        // shared holding byte and read-only capture (R3, R7)
        '{2'd0, 3'd1, 8'hAB, 8'h00, 4'd3},
        '{2'd1, 3'd5, 8'h00, 8'hAB, 4'd3},
        '{2'd0, 3'd4, 8'h55, 8'h00, 4'd7},
        '{2'd1, 3'd4, 8'h00, 8'h00, 4'd7},
        '{2'd1, 3'd5, 8'h00, 8'h00, 4'd7},
        // unused addresses (R9), then counter still idle (R4)
        '{2'd0, 3'd6, 8'h99, 8'h00, 4'd9},
        '{2'd1, 3'd6, 8'h00, 8'h00, 4'd9},
        '{2'd1, 3'd7, 8'h00, 8'h00, 4'd9},
        '{2'd1, 3'd2, 8'h00, 8'h34, 4'd9},
        '{2'd1, 3'd0, 8'h00, 8'h00, 4'd4}
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // All operations start 1 ns after a rising edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input int req);
        bus_rd = 1'b1; bus_addr = a;
        #1 check(bus_rdata, exp, req);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #20000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8: reset state
        check({7'd0, match_pulse}, 8'h00, 8);
        rd(3'd0, 8'h00, 8);
        rd(3'd2, 8'h00, 8);
        rd(3'd4, 8'h00, 8);
        rd(3'd1, 8'h00, 8);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                2'd0: wr(VECS[i].addr, VECS[i].data);
                2'd1: rd(VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
                default: ticks(int'(VECS[i].data));
            endcase
        end

        // R6: match pulse when stepping onto compare value 0x0010
        wr(3'd3, 8'h00); wr(3'd2, 8'h10);
        wr(3'd1, 8'h00); wr(3'd0, 8'h0E);
        tick = 1'b1;
        @(posedge clk); #1;
        check({7'd0, match_pulse}, 8'h00, 6);
        @(posedge clk); #1;
        check({7'd0, match_pulse}, 8'h01, 6);
        tick = 1'b0;
        @(posedge clk); #1;
        check({7'd0, match_pulse}, 8'h00, 6);
        rd(3'd0, 8'h10, 6);

        // R6 and R5: a load onto the compare value gives no pulse
        wr(3'd1, 8'h00);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h10;
        @(posedge clk); #1;
        tick = 1'b0; bus_wr = 1'b0;
        check({7'd0, match_pulse}, 8'h00, 6);
        rd(3'd0, 8'h10, 5);

        // R5: load colliding with a tick, then one more tick
        wr(3'd1, 8'h40);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h00;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        @(posedge clk); #1;
        tick = 1'b0;
        rd(3'd0, 8'h01, 5);
        rd(3'd1, 8'h40, 5);

        // R7: capture edge selection (counter stopped)
        wr(3'd1, 8'h12); wr(3'd0, 8'h34);
        cap_rise = 1'b1; cap_pin = 1'b1;
        idle(3);
        rd(3'd4, 8'h34, 7);
        rd(3'd5, 8'h12, 7);
        wr(3'd1, 8'h22); wr(3'd0, 8'h22);
        cap_pin = 1'b0;
        idle(3);
        rd(3'd4, 8'h34, 7);
        cap_rise = 1'b0;
        wr(3'd1, 8'h33); wr(3'd0, 8'h33);
        cap_pin = 1'b1;
        idle(3);
        rd(3'd4, 8'h34, 7);
        cap_pin = 1'b0;
        idle(3);
        rd(3'd4, 8'h33, 7);
        rd(3'd5, 8'h33, 7);

        // R8: reset in the middle of operation
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(3'd0, 8'h00, 8);
        rd(3'd1, 8'h00, 8);
        rd(3'd2, 8'h00, 8);
        rd(3'd3, 8'h00, 8);
        rd(3'd4, 8'h00, 8);

        summary();
    end

endmodule